// File: doc/BRIEF.md
# Eight-Channel Transmit Queue Scheduler with Pause Gating

This block decides which of eight transmit queues may start the next frame. Each queue raises a pending bit while it has a frame ready. A runtime mode input selects between strict priority, where the highest-numbered queue always wins, and rotating service, which moves upward through the queue numbers and wraps back to zero. Once a queue is granted, the grant is held for the whole frame. It is released or handed on only when the transmit path signals end of frame.

The block also holds a flow-control pause timer. When the link is full duplex and transmit flow control is enabled, a received pause request loads the timer with the requested number of quanta. An external tick marks each elapsed quantum, and the timer counts down on each tick. While the timer is non-zero, no new frame is granted. A frame that is already on the wire is allowed to finish. In half-duplex operation, or with flow control off, pause requests leave the timer untouched. The remaining count is exposed on a port so that software can read it.

Top module: `txq_arbiter`

## Requirements
- R1: After reset, grant_valid is 0, grant_chan is 0 and pause_left is 0. The first rotating search starts at queue 0.
- R2: When rr_mode is 0, a new grant goes to the highest-numbered pending queue.
- R3: When rr_mode is 1, a new grant goes to the first pending queue found by searching upward from the last served queue plus one, modulo 8. Queues with nothing pending are skipped within the same cycle.
- R4: While a grant is active and frame_done is low, grant_valid stays 1 and grant_chan stays unchanged, whatever the pending inputs do.
- R5: A scheduling decision is made on any clock edge where no grant is active, or where frame_done is high during an active grant. If at least one queue is pending and pause does not block, the grant appears on the next cycle. If no queue is pending, grant_valid is 0 on the next cycle.
- R6: A pause_load with full_duplex=1 and flow_en=1 sets pause_left to pause_value on the next cycle. This load takes precedence over a tick in the same cycle.
- R7: A pause_load while full_duplex or flow_en is 0 leaves pause_left unchanged.
- R8: Without a load, each quantum_tick lowers a non-zero pause_left by one. At zero, pause_left stays at zero.
- R9: No new grant is issued while pause_left is non-zero and both full_duplex and flow_en are 1. A grant that is already active is not withdrawn by a pause.
- R10: Loading a pause value of 0 clears pause_left on the next cycle, and a grant can be issued on the edge after that.
- R11: A frame_done pulse while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rr_mode | input | 1 | 0: strict priority (highest index wins), 1: rotating service |
| full_duplex | input | 1 | Link runs full duplex |
| flow_en | input | 1 | Transmit flow control enabled |
| pending | input | 8 | Per-queue frame-ready flags, bit n for queue n |
| frame_done | input | 1 | End-of-frame pulse from the transmit path |
| pause_load | input | 1 | A pause request was received |
| pause_value | input | 16 | Pause duration in quanta |
| quantum_tick | input | 1 | One pause quantum (512 bit times) elapsed |
| grant_valid | output | 1 | A queue holds the transmit path |
| grant_chan | output | 3 | Index of the granted queue |
| pause_left | output | 16 | Remaining pause quanta |

## Verification
Each result comes out of a single register stage. A grant decision, a timer load and a countdown step all appear on the outputs one cycle after the edge at which their inputs were sampled. A pause load therefore blocks decisions from the following edge onward, not at its own edge. The bench drives its inputs one time unit after a rising edge. Just before the next edge, it advances a reference model from those inputs. It then compares all three outputs one time unit after that edge. As a result, every comparison sits exactly one register away from the stimulus that caused it.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;

endpackage

// File: rtl/txq_pick.sv
// Combinational queue selector: strict priority or rotating search.
module txq_pick #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  last,
    input  txq_pkg::prio_mode_e mode,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] fixed_idx;
    logic [IDX_W-1:0] rot_idx;

    // Strict priority: scan upward so the highest set bit wins.
    always_comb begin
        fixed_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i]) fixed_idx = IDX_W'(i);
        end
    end

    // Rotating: scan offsets from far to near so the nearest after 'last' wins.
    always_comb begin
        rot_idx = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int c;
            c = (int'(last) + k) % NUM_CH;
            if (req[c]) rot_idx = IDX_W'(c);
        end
    end

    assign any = |req;
    assign idx = (mode == txq_pkg::PRIO_ROTATE) ? rot_idx : fixed_idx;

endmodule

// File: rtl/txq_pause_timer.sv
// Pause quanta countdown; load wins over tick, saturates at zero.
module txq_pause_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] value,
    input  logic             tick,
    output logic [TMR_W-1:0] count
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = value;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/txq_arbiter.sv
// Frame-granular transmit queue scheduler with flow-control pause gating.
module txq_arbiter #(
    parameter int NUM_CH = 8,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_mode,
    input  logic              full_duplex,
    input  logic              flow_en,
    input  logic [NUM_CH-1:0] pending,
    input  logic              frame_done,
    input  logic              pause_load,
    input  logic [TMR_W-1:0]  pause_value,
    input  logic              quantum_tick,
    output logic              grant_valid,
    output logic [$clog2(NUM_CH)-1:0] grant_chan,
    output logic [TMR_W-1:0]  pause_left
);

    localparam int IDX_W = $clog2(NUM_CH);
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NUM_CH - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] chan;
        logic [IDX_W-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic             pause_gate;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [TMR_W-1:0] tmr_count;
    txq_pkg::prio_mode_e mode;

    assign pause_gate = full_duplex & flow_en;
    assign mode       = rr_mode ? txq_pkg::PRIO_ROTATE : txq_pkg::PRIO_FIXED;

    txq_pick #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req  (pending),
        .last (st_q.last),
        .mode (mode),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    txq_pause_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pause_load & pause_gate),
        .value (pause_value),
        .tick  (quantum_tick),
        .count (tmr_count)
    );

    always_comb begin
        logic blocked;
        logic free;
        st_d    = st_q;
        blocked = pause_gate && (tmr_count != '0);
        free    = !st_q.busy || frame_done;
        if (free) begin
            if (pick_any && !blocked) begin
                st_d.busy = 1'b1;
                st_d.chan = pick_idx;
                st_d.last = pick_idx;
            end else begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.chan <= '0;
            st_q.last <= LAST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.busy;
    assign grant_chan  = st_q.chan;
    assign pause_left  = tmr_count;

endmodule

// File: rtl/txq_arbiter_chk.sv
module txq_arbiter_chk #(
    parameter int NUM_CH = 8,
    parameter int TMR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rr_mode,
    input logic              full_duplex,
    input logic              flow_en,
    input logic [NUM_CH-1:0] pending,
    input logic              frame_done,
    input logic              pause_load,
    input logic [TMR_W-1:0]  pause_value,
    input logic              quantum_tick,
    input logic              grant_valid,
    input logic [$clog2(NUM_CH)-1:0] grant_chan,
    input logic [TMR_W-1:0]  pause_left
);

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !frame_done |=> grant_valid && $stable(grant_chan));

    // R6
    pause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_load && full_duplex && flow_en |=> pause_left == $past(pause_value));

    // R7
    pause_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_load && !(full_duplex && flow_en) && !quantum_tick |=> $stable(pause_left));

    // R8
    pause_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_load && quantum_tick && (pause_left != '0)
        |=> pause_left == $past(pause_left) - TMR_W'(1));

    // R9
    pause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid && (pause_left != '0) && full_duplex && flow_en |=> !grant_valid);

    // R2
    fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && !$past(rr_mode)
        |-> ((($past(pending)) >> grant_chan) >> 1) == '0);

endmodule

bind txq_arbiter txq_arbiter_chk #(.NUM_CH(NUM_CH), .TMR_W(TMR_W)) u_chk (.*);

// File: tb/txq_arbiter_bench.sv
module txq_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rr_mode = 1'b0;
    logic        full_duplex = 1'b1;
    logic        flow_en = 1'b1;
    logic [7:0]  pending = '0;
    logic        frame_done = 1'b0;
    logic        pause_load = 1'b0;
    logic [15:0] pause_value = '0;
    logic        quantum_tick = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_chan;
    logic [15:0] pause_left;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    bit       m_busy = 1'b0;
    bit [2:0] m_chan = '0;
    bit [2:0] m_last = 3'd7;
    bit [15:0] m_tmr = '0;

    always #2 clk = ~clk;

    txq_arbiter u_txq_arbiter (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .full_duplex(full_duplex),
        .flow_en(flow_en), .pending(pending), .frame_done(frame_done),
        .pause_load(pause_load), .pause_value(pause_value),
        .quantum_tick(quantum_tick), .grant_valid(grant_valid),
        .grant_chan(grant_chan), .pause_left(pause_left)
    );

    function automatic bit [2:0] ref_fixed(input bit [7:0] p);
        for (int i = 7; i >= 0; i--) if (p[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic bit [2:0] ref_rotate(input bit [7:0] p, input bit [2:0] last);
        for (int k = 1; k <= 8; k++) begin
            int c = (int'(last) + k) % 8;
            if (p[c]) return 3'(c);
        end
        return 3'd0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: advance model from current inputs, then compare after the edge
    task automatic step(input string req);
        bit        gate = full_duplex && flow_en;
        bit        blk  = gate && (m_tmr != 0);
        bit        n_busy = m_busy;
        bit [2:0]  n_chan = m_chan;
        bit [2:0]  n_last = m_last;
        bit [15:0] n_tmr  = m_tmr;
        bit [2:0]  pk;
        if (pause_load && gate)          n_tmr = pause_value;
        else if (quantum_tick && m_tmr != 0) n_tmr = m_tmr - 16'd1;
        if (!m_busy || frame_done) begin
            if (pending != 0 && !blk) begin
                pk = rr_mode ? ref_rotate(pending, m_last) : ref_fixed(pending);
                n_busy = 1'b1; n_chan = pk; n_last = pk;
            end else begin
                n_busy = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        m_busy = n_busy; m_chan = n_chan; m_last = n_last; m_tmr = n_tmr;
        check(req, "grant_valid", int'(grant_valid), int'(m_busy));
        if (m_busy) check(req, "grant_chan", int'(grant_chan), int'(m_chan));
        check(req, "pause_left", int'(pause_left), int'(m_tmr));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "grant_valid", int'(grant_valid), 0);
        check("R1", "grant_chan", int'(grant_chan), 0);
        check("R1", "pause_left", int'(pause_left), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 strict priority: highest index of 0010_0110 is 5
        pending = 8'h26;
        step("R2");
        check("R2", "fixed pick", int'(grant_chan), 5);
        // R4 pending withdrawn mid-frame: grant held
        pending = 8'h00;
        step("R4");
        check("R4", "held valid", int'(grant_valid), 1);
        // R5 end of frame with nothing pending drops the grant
        frame_done = 1'b1;
        step("R5");
        check("R5", "drop", int'(grant_valid), 0);
        // R11 end of frame while idle
        step("R11");
        check("R11", "idle done", int'(grant_valid), 0);
        frame_done = 1'b0;

        // R6 / R9 / R8 pause sequence
        pause_load = 1'b1; pause_value = 16'd3;
        step("R6");
        check("R6", "loaded", int'(pause_left), 3);
        pause_load = 1'b0; pending = 8'h01;
        step("R9");
        check("R9", "blocked", int'(grant_valid), 0);
        quantum_tick = 1'b1;
        step("R8");
        check("R8", "count", int'(pause_left), 2);
        step("R8");
        step("R8");
        check("R8", "zero", int'(pause_left), 0);
        step("R8");
        check("R8", "saturate", int'(pause_left), 0);
        check("R9", "resumed", int'(grant_valid), 1);
        quantum_tick = 1'b0;
        // R9 pause mid-frame does not withdraw grant
        pause_load = 1'b1; pause_value = 16'd5;
        step("R9");
        check("R9", "not cut", int'(grant_valid), 1);
        // R10 zero load clears, regrant on next edge
        pause_value = 16'd0;
        step("R10");
        check("R10", "cleared", int'(pause_left), 0);
        pause_load = 1'b0; frame_done = 1'b1;
        step("R10");
        check("R10", "regrant", int'(grant_valid), 1);
        frame_done = 1'b0;
        // R7 half-duplex ignores the load
        full_duplex = 1'b0; pause_load = 1'b1; pause_value = 16'd9;
        step("R7");
        check("R7", "ignored", int'(pause_left), 0);
        full_duplex = 1'b1; flow_en = 1'b0;
        step("R7");
        check("R7", "ignored flow", int'(pause_left), 0);
        pause_load = 1'b0; flow_en = 1'b1;
        frame_done = 1'b1; pending = 8'h00;
        step("R5");
        frame_done = 1'b0;

        // R3 rotating: after reset-like idle, last=0 served; pending 0x81 -> 7 then 0
        rr_mode = 1'b1; pending = 8'h81;
        step("R3");
        check("R3", "rotate first", int'(grant_chan), 7);
        frame_done = 1'b1;
        step("R3");
        check("R3", "rotate wrap", int'(grant_chan), 0);
        frame_done = 1'b0;

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) rr_mode = ~rr_mode;
            if (n % 300 == 0) begin
                full_duplex = ($urandom % 4) != 0;
                flow_en     = ($urandom % 4) != 0;
            end
            pending      = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
            frame_done   = ($urandom % 4) == 0;
            pause_load   = ($urandom % 40) == 0;
            pause_value  = (($urandom % 5) == 0) ? 16'd0 : 16'($urandom % 20);
            quantum_tick = ($urandom % 3) == 0;
            step(rr_mode ? "R3" : "R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule